// File: doc/BRIEF.md
# Block Cipher Phase Sequencer with Access-Error Flags

This block controls the traffic between a register interface and a 128-bit block-cipher core. Software or a DMA engine writes one block as a series of 32-bit words. After the last word of the block, the sequencer issues a one-cycle start pulse to the core. It then waits for the core's done pulse. After that it allows the result to be read out as the same number of 32-bit words. Once the last result word has been read, it goes back to accepting input. The cipher core itself is not part of this block. It is reached only through the start/done handshake and the per-word index and accept strobes that steer the external data path.

While the block is enabled, it watches every access for the wrong phase. A result read that arrives before the result exists sets a sticky read-error flag. An input write that arrives while the core is busy, or while the result is waiting to be read, sets a sticky write-error flag. Such an access is refused: no counter moves and no accept strobe fires. A completion flag marks each finished block. The two error flags share one maskable interrupt, and the completion flag has its own maskable interrupt. Software clears each flag through its own clear strobe. Two request lines pace a DMA engine: one for input words and one for output words.

Top module: `cipher_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, `phase` is 0 (idle), and every flag, request, index and strobe is 0. With `enable` high in idle, the next cycle shows `phase` = 1 (input).
- R2: An accepted write that is the last word of the block (`in_idx` = 3) moves `phase` to 2 (compute) on the next cycle. In that cycle `core_start` is high, and it is high for exactly that one cycle.
- R3: `wr_accept` is high only for a write with `enable` high in phase 1. `rd_accept` is high only for a read with `enable` high in phase 3. `in_idx` and `out_idx` count the accepted words of the current block, from 0 to 3.
- R4: A read with `enable` high in phase 1 or phase 2 sets `rderr` on the next cycle. The flag then stays set until it is cleared.
- R5: A write with `enable` high in phase 2 or phase 3 sets `wrerr` on the next cycle. The flag then stays set until it is cleared.
- R6: `core_done` in phase 2 sets `ccf` and moves `phase` to 3 (output) on the next cycle. A done pulse in any other phase has no effect.
- R7: `err_irq` equals `errie` AND (`rderr` OR `wrerr`). `ccf_irq` equals `ccfie` AND `ccf`.
- R8: `dma_in_req` is high exactly when `enable` and `dma_in_en` are high in phase 1. `dma_out_req` is high exactly when `enable` and `dma_out_en` are high in phase 3.
- R9: A clear strobe drops its flag on the next cycle. If a set of the same flag happens in the same cycle, the set wins.
- R10: With `enable` low, the next cycle shows phase 0 and both indices at 0, and all three flags keep their values. Accesses made while `enable` is low set no flag.
- R11: The accepted read with `out_idx` = 3 returns `phase` to 1 with both indices at 0.
- R12: A refused (erroneous) access leaves `in_idx`, `out_idx` and `phase` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| din_wr | input | 1 | Write strobe of the input data register |
| dout_rd | input | 1 | Read strobe of the output data register |
| core_done | input | 1 | Completion pulse from the cipher core |
| clr_rderr | input | 1 | Clear strobe for the read-error flag |
| clr_wrerr | input | 1 | Clear strobe for the write-error flag |
| clr_ccf | input | 1 | Clear strobe for the completion flag |
| errie | input | 1 | Error interrupt enable |
| ccfie | input | 1 | Completion interrupt enable |
| dma_in_en | input | 1 | Enable for input DMA requests |
| dma_out_en | input | 1 | Enable for output DMA requests |
| phase | output | 2 | 0 idle, 1 input, 2 compute, 3 output |
| core_start | output | 1 | One-cycle start pulse to the core |
| wr_accept | output | 1 | Current write is taken into the data path |
| rd_accept | output | 1 | Current read is served by the data path |
| in_idx | output | 2 | Word slot of the next input word |
| out_idx | output | 2 | Word slot of the next output word |
| rderr | output | 1 | Sticky read-error flag |
| wrerr | output | 1 | Sticky write-error flag |
| ccf | output | 1 | Sticky computation-complete flag |
| err_irq | output | 1 | Masked error interrupt |
| ccf_irq | output | 1 | Masked completion interrupt |
| dma_in_req | output | 1 | DMA request for an input word |
| dma_out_req | output | 1 | DMA request for an output word |

## Verification
The bench builds the block with the default 32-bit word and 128-bit block. This gives four words per direction, so every index wrap, last-word transition and start pulse is reached within a few cycles per block. The bench runs a behavioural model of the phase and the flags beside the design, and compares all outputs every cycle. With this short block length, a single run can cover each access in each phase, clears that collide with sets, stray done pulses, and a disable in the middle of a block.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_CRUNCH = 2'd2,
    PH_DRAIN  = 2'd3
  } phase_e;

  localparam int FLAG_RD   = 0;
  localparam int FLAG_WR   = 1;
  localparam int FLAG_DONE = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/cpc_word_ctr.sv
`timescale 1ns/1ps
module cpc_word_ctr #(
  parameter int WORDS = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic          cnt_en;
  logic [CW-1:0] cnt_d;

  assign at_last = (cnt == LAST);

  always_comb begin
    cnt_en = clr | inc;
    if (clr || at_last) cnt_d = '0;
    else                cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/cpc_sticky_flag.sv
`timescale 1ns/1ps
module cpc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_en;
  logic q_d;

  always_comb begin
    q_en = set | clr;
    q_d  = set;          // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/cpc_phase_fsm.sv
`timescale 1ns/1ps
module cpc_phase_fsm
  import cpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   load_hit,
  input  logic   load_last,
  input  logic   drain_hit,
  input  logic   drain_last,
  input  logic   core_done,
  output phase_e phase,
  output logic   core_start
);
  phase_e phase_d;
  logic   start_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE:   phase_d = PH_LOAD;
      PH_LOAD:   if (load_hit && load_last)   phase_d = PH_CRUNCH;
      PH_CRUNCH: if (core_done)               phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_hit && drain_last) phase_d = PH_LOAD;
      default:   phase_d = PH_IDLE;
    endcase
    if (!enable) phase_d = PH_IDLE;
    start_d = enable && (phase == PH_LOAD) && load_hit && load_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      core_start <= 1'b0;
    end else begin
      phase      <= phase_d;
      core_start <= start_d;
    end
  end
endmodule

// File: rtl/cipher_phase_ctrl.sv
`timescale 1ns/1ps
module cipher_phase_ctrl
  import cpc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 128,
  localparam int WORDS  = BLOCK_W / WORD_W,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             din_wr,
  input  logic             dout_rd,
  input  logic             core_done,
  input  logic             clr_rderr,
  input  logic             clr_wrerr,
  input  logic             clr_ccf,
  input  logic             errie,
  input  logic             ccfie,
  input  logic             dma_in_en,
  input  logic             dma_out_en,
  output logic [1:0]       phase,
  output logic             core_start,
  output logic             wr_accept,
  output logic             rd_accept,
  output logic [IDX_W-1:0] in_idx,
  output logic [IDX_W-1:0] out_idx,
  output logic             rderr,
  output logic             wrerr,
  output logic             ccf,
  output logic             err_irq,
  output logic             ccf_irq,
  output logic             dma_in_req,
  output logic             dma_out_req
);
  phase_e cur;
  logic   in_last, out_last;
  logic   in_ph, busy_ph, out_ph;
  logic   rd_bad, wr_bad, done_hit;
  logic   ctr_clr;
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_q;

  always_comb begin
    in_ph     = enable && (cur == PH_LOAD);
    busy_ph   = enable && (cur == PH_CRUNCH);
    out_ph    = enable && (cur == PH_DRAIN);
    wr_accept = din_wr  && in_ph;
    rd_accept = dout_rd && out_ph;
    wr_bad    = din_wr  && (busy_ph || out_ph);
    rd_bad    = dout_rd && (in_ph || busy_ph);
    done_hit  = core_done && busy_ph;
    ctr_clr   = !enable;
  end

  cpc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .load_hit   (wr_accept),
    .load_last  (in_last),
    .drain_hit  (rd_accept),
    .drain_last (out_last),
    .core_done  (done_hit),
    .phase      (cur),
    .core_start (core_start)
  );

  cpc_word_ctr #(.WORDS(WORDS), .CW(IDX_W)) u_in_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctr_clr),
    .inc     (wr_accept),
    .cnt     (in_idx),
    .at_last (in_last)
  );

  cpc_word_ctr #(.WORDS(WORDS), .CW(IDX_W)) u_out_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctr_clr),
    .inc     (rd_accept),
    .cnt     (out_idx),
    .at_last (out_last)
  );

  always_comb begin
    f_set            = '0;
    f_clr            = '0;
    f_set[FLAG_RD]   = rd_bad;
    f_set[FLAG_WR]   = wr_bad;
    f_set[FLAG_DONE] = done_hit;
    f_clr[FLAG_RD]   = clr_rderr;
    f_clr[FLAG_WR]   = clr_wrerr;
    f_clr[FLAG_DONE] = clr_ccf;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    cpc_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (f_set[g]),
      .clr   (f_clr[g]),
      .q     (f_q[g])
    );
  end

  always_comb begin
    phase       = cur;
    rderr       = f_q[FLAG_RD];
    wrerr       = f_q[FLAG_WR];
    ccf         = f_q[FLAG_DONE];
    err_irq     = errie && (rderr || wrerr);
    ccf_irq     = ccfie && ccf;
    dma_in_req  = in_ph  && dma_in_en;
    dma_out_req = out_ph && dma_out_en;
  end
endmodule

// File: rtl/cipher_phase_ctrl_chk.sv
`timescale 1ns/1ps
module cipher_phase_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       din_wr,
  input logic       dout_rd,
  input logic       core_done,
  input logic       clr_ccf,
  input logic [1:0] phase,
  input logic       core_start,
  input logic [1:0] in_idx,
  input logic [1:0] out_idx,
  input logic       rderr,
  input logic       wrerr,
  input logic       ccf,
  input logic       dma_in_req,
  input logic       dma_out_req
);
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  p_start_in_compute_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (phase == 2'd2));
  p_rderr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && dout_rd && (phase == 2'd1 || phase == 2'd2)) |=> rderr);
  p_wrerr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && din_wr && (phase == 2'd2 || phase == 2'd3)) |=> wrerr);
  p_done_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && core_done && phase == 2'd2) |=> (ccf && phase == 2'd3));
  p_dma_in_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_in_req |-> (enable && phase == 2'd1));
  p_dma_out_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_out_req |-> (enable && phase == 2'd3));
  p_ccf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ccf && !(enable && core_done && phase == 2'd2)) |=> !ccf);
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 2'd0 && in_idx == 2'd0 && out_idx == 2'd0));
  p_no_advance_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == 2'd3 && !dout_rd) |=> $stable(out_idx));
endmodule

bind cipher_phase_ctrl cipher_phase_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .din_wr      (din_wr),
  .dout_rd     (dout_rd),
  .core_done   (core_done),
  .clr_ccf     (clr_ccf),
  .phase       (phase),
  .core_start  (core_start),
  .in_idx      (in_idx),
  .out_idx     (out_idx),
  .rderr       (rderr),
  .wrerr       (wrerr),
  .ccf         (ccf),
  .dma_in_req  (dma_in_req),
  .dma_out_req (dma_out_req)
);

// File: tb/cipher_phase_ctrl_tb.sv
`timescale 1ns/1ps
module cipher_phase_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 0, din_wr = 0, dout_rd = 0, core_done = 0;
  logic clr_rderr = 0, clr_wrerr = 0, clr_ccf = 0;
  logic errie = 0, ccfie = 0, dma_in_en = 0, dma_out_en = 0;
  logic [1:0] phase, in_idx, out_idx;
  logic core_start, wr_accept, rd_accept, rderr, wrerr, ccf;
  logic err_irq, ccf_irq, dma_in_req, dma_out_req;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // behavioural reference state
  int  m_ph = 0, m_in = 0, m_out = 0;
  bit  m_start = 0, m_rd = 0, m_wr = 0, m_ccf = 0;

  always #4 clk = ~clk;

  cipher_phase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .din_wr(din_wr),
    .dout_rd(dout_rd), .core_done(core_done), .clr_rderr(clr_rderr),
    .clr_wrerr(clr_wrerr), .clr_ccf(clr_ccf), .errie(errie), .ccfie(ccfie),
    .dma_in_en(dma_in_en), .dma_out_en(dma_out_en), .phase(phase),
    .core_start(core_start), .wr_accept(wr_accept), .rd_accept(rd_accept),
    .in_idx(in_idx), .out_idx(out_idx), .rderr(rderr), .wrerr(wrerr),
    .ccf(ccf), .err_irq(err_irq), .ccf_irq(ccf_irq),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
  );

  function automatic bit e_wacc();
    return enable && din_wr && m_ph == 1;
  endfunction
  function automatic bit e_racc();
    return enable && dout_rd && m_ph == 3;
  endfunction
  function automatic bit e_werr();
    return enable && din_wr && (m_ph == 2 || m_ph == 3);
  endfunction
  function automatic bit e_rerr();
    return enable && dout_rd && (m_ph == 1 || m_ph == 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_in = 0; m_out = 0; m_start = 0;
      m_rd = 0; m_wr = 0; m_ccf = 0;
    end else begin
      bit wa, ra, we, re, dn;
      wa = e_wacc(); ra = e_racc(); we = e_werr(); re = e_rerr();
      dn = enable && core_done && m_ph == 2;
      m_rd  = re ? 1'b1 : (clr_rderr ? 1'b0 : m_rd);
      m_wr  = we ? 1'b1 : (clr_wrerr ? 1'b0 : m_wr);
      m_ccf = dn ? 1'b1 : (clr_ccf   ? 1'b0 : m_ccf);
      m_start = 0;
      if (!enable) begin
        m_ph = 0; m_in = 0; m_out = 0;
      end else begin
        case (m_ph)
          0: m_ph = 1;
          1: if (wa) begin
               if (m_in == 3) begin m_in = 0; m_ph = 2; m_start = 1; end
               else m_in++;
             end
          2: if (dn) m_ph = 3;
          default: if (ra) begin
               if (m_out == 3) begin m_out = 0; m_ph = 1; end
               else m_out++;
             end
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1/R2/R6/R10/R11 phase", phase, m_ph);
      chk("R2 core_start", core_start, m_start);
      chk("R3 wr_accept", wr_accept, e_wacc());
      chk("R3 rd_accept", rd_accept, e_racc());
      chk("R3/R12 in_idx", in_idx, m_in);
      chk("R3/R12 out_idx", out_idx, m_out);
      chk("R4/R9 rderr", rderr, m_rd);
      chk("R5/R9 wrerr", wrerr, m_wr);
      chk("R6/R9 ccf", ccf, m_ccf);
      chk("R7 err_irq", err_irq, errie && (m_rd || m_wr));
      chk("R7 ccf_irq", ccf_irq, ccfie && m_ccf);
      chk("R8 dma_in_req", dma_in_req, enable && dma_in_en && m_ph == 1);
      chk("R8 dma_out_req", dma_out_req, enable && dma_out_en && m_ph == 3);
    end
  end

  // one cycle of stimulus, applied shortly after a rising edge
  task automatic cyc(bit w, bit r, bit d, bit cr, bit cw, bit cc);
    @(posedge clk); #2;
    din_wr = w; dout_rd = r; core_done = d;
    clr_rderr = cr; clr_wrerr = cw; clr_ccf = cc;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);                                  // R1 reset state
    @(posedge clk); #2; rst_n = 1;
    idle(2);
    errie = 1; ccfie = 1; dma_in_en = 1; dma_out_en = 1; enable = 1;
    idle(2);                                  // R1 idle -> input
    // R3 R2 normal block with a gap
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); idle(1);
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0);
    idle(3);
    cyc(0,0,1,0,0,0);                          // R6 done
    idle(1);
    cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0); idle(1);
    cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0);        // R11 back to input
    idle(1);
    cyc(0,0,0,0,0,1);                          // R9 clear ccf
    // R4 read in input; R6 stray done in input
    cyc(0,1,0,0,0,0); cyc(0,0,1,0,0,0);
    cyc(1,1,0,0,0,0);                          // write accepted + read error
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0);
    // R5 R12 compute phase misuse
    cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0); cyc(1,1,0,1,1,0);
    cyc(0,0,1,0,0,0);
    cyc(1,0,0,0,0,0);                          // R5 write in output
    cyc(1,1,0,0,0,0);                          // read accepted + write error
    cyc(0,0,0,1,1,1);                          // R9 clear all
    errie = 0; idle(1); errie = 1;             // R7 mask
    cyc(1,0,0,0,1,0);                          // R9 set wins over clear
    dma_out_en = 0; idle(1); dma_out_en = 1;   // R8
    // R10 disable mid-output, accesses ignored
    enable = 0; cyc(1,1,1,0,0,0); cyc(1,1,0,0,0,0); idle(1);
    enable = 1; idle(2);
    dma_in_en = 0; cyc(1,0,0,0,0,0); dma_in_en = 1;
    cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0);        // R6 done in input ignored
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0);
    cyc(0,0,1,0,0,1);                          // done + clear ccf: set wins
    cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0);
    enable = 0; idle(2);                       // R10 flags preserved
    rst_n = 0; idle(2);                        // R1 async reset
    @(negedge clk); #1;
    finish_run();
  end
endmodule